// File: doc/BRIEF.md
# Receive Cell Queue with Byte-Wide Upstream Port

This block sits between the line-side receive path and an upstream ATM layer device. The line side presents 53-byte cells one byte per clock. Each cell is marked with a start flag on its first byte. The block stores only complete cells in a small cell queue. It then hands them out over an 8-bit cell-level receive port. That port carries data, odd parity, a start-of-cell marker and a cell-available flag. Transfers are paced by an active-low receive enable.

Three static controls shape the upstream port. The first selects early cell-available indication: the flag drops once payload byte 44 of the final queued cell has been taken, not after its last byte. The second selects multi-PHY operation, where the output enable for the data, parity and start-of-cell pads follows the receive enable. The third is a flush request that empties the queue and clears its own busy bit when it is done. A one-cycle active-low pulse reports each cell that enters the queue.

Top module: `cellq_rx_top`

## Requirements
- R1: After reset, cell_avail_o and rd_soc_o are 0, flush_busy_o is 0 and rx_cell_no is 1.
- R2: A cell is 53 bytes written with wr_sof_i on byte 0. Once queued, its bytes are presented in write order on rd_data_o. One byte advances per clock edge at which rd_en_ni is 0. The output holds while rd_en_ni is 1. rd_soc_o is 1 only while byte 0 is presented.
- R3: rd_par_o makes the 9 bits {rd_data_o, rd_par_o} odd parity.
- R4: A partially written cell is never offered: cell_avail_o and rd_soc_o stay 0 until the 53rd byte of a cell is written.
- R5: With cfg_early_i = 0, cell_avail_o stays 1 through the presentation of byte index 52 of the last queued cell. It is 0 in the cycle after that byte is taken, unless another cell is queued.
- R6: With cfg_early_i = 1 and only one cell queued, cell_avail_o is 1 while byte indices 0 to 48 are presented. It is 0 once index 48 (payload byte 44) has been taken.
- R7: With cfg_multi_i = 0, rd_oe_o is always 1.
- R8: With cfg_multi_i = 1, rd_oe_o equals the inverse of rd_en_ni.
- R9: A flush_req_i pulse sets flush_busy_o in the next cycle. At the following edge the queue is emptied and flush_busy_o returns to 0.
- R10: rx_cell_no is 0 for exactly the one cycle after the last byte of a cell enters the queue, and 1 otherwise.
- R11: The queue holds 4 cells. A cell whose start byte arrives while 4 cells are queued is dropped whole: it raises no rx_cell_no pulse and is never read out.
- R12: A start byte arriving in the middle of a cell discards the partial cell and begins a new one.
- R13: While no cell is queued, rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Line-side byte valid |
| wr_sof_i | input | 1 | Marks byte 0 of a cell |
| wr_data_i | input | 8 | Line-side byte |
| cfg_early_i | input | 1 | 1 selects early cell-available drop |
| cfg_multi_i | input | 1 | 1 selects multi-PHY output enable |
| flush_req_i | input | 1 | Pulse requesting a queue flush |
| rd_en_ni | input | 1 | Upstream receive enable, active low |
| rd_data_o | output | 8 | Upstream data byte |
| rd_par_o | output | 1 | Odd parity of rd_data_o |
| rd_soc_o | output | 1 | Start of cell on rd_data_o |
| cell_avail_o | output | 1 | A complete cell can be read |
| rd_oe_o | output | 1 | Drive enable for data, parity and start-of-cell pads |
| flush_busy_o | output | 1 | Flush in progress, self-clearing |
| rx_cell_no | output | 1 | Active-low pulse per queued cell |

## Verification
Data, parity, start-of-cell and cell-available are decoded from registered state with no added delay. The value presented before an edge is therefore the byte that edge takes. The bench drives inputs on the falling edge and samples the outputs at the next falling edge, which is half a cycle after the edge that changed them. The cell-queued pulse appears one cycle after the final write byte, and the flush completes two edges after its request. Each check is placed on exactly that falling edge. The output enable is combinational, so the bench checks it a small delay after it drives rd_en_ni.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 5;
  localparam int EARLY_PAY  = 44;
  // first byte index after payload byte 44 has been taken
  localparam int EARLY_IDX  = HDR_BYTES + EARLY_PAY;
  localparam int IDX_W      = $clog2(CELL_BYTES);

  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction
endpackage

// File: rtl/cellq_wr_ctl.sv
module cellq_wr_ctl #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       valid_i,
  input  logic                       sof_i,
  input  logic                       full_i,
  output logic                       we_o,
  output logic [PW-1:0]              ptr_o,
  output logic [cellq_pkg::IDX_W-1:0] idx_o,
  output logic                       commit_o
);
  import cellq_pkg::*;

  logic              in_cell_q, drop_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PW-1:0]     ptr_q;
  logic              last_byte;

  assign last_byte = (idx_q == IDX_W'(CELL_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cell_q <= 1'b0;
      drop_q    <= 1'b0;
      idx_q     <= '0;
      ptr_q     <= '0;
    end else if (clr_i) begin
      in_cell_q <= 1'b0;
      drop_q    <= 1'b0;
      idx_q     <= '0;
      ptr_q     <= '0;
    end else if (valid_i) begin
      if (sof_i) begin
        // restart: a partial cell in this slot is simply overwritten
        in_cell_q <= 1'b1;
        drop_q    <= full_i;
        idx_q     <= IDX_W'(1);
      end else if (in_cell_q) begin
        if (last_byte) begin
          in_cell_q <= 1'b0;
          idx_q     <= '0;
          if (!drop_q) begin
            if (ptr_q == PW'(DEPTH - 1)) ptr_q <= '0;
            else                         ptr_q <= ptr_q + PW'(1);
          end
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    we_o     = 1'b0;
    commit_o = 1'b0;
    idx_o    = idx_q;
    if (valid_i && !clr_i) begin
      if (sof_i) begin
        we_o  = !full_i;
        idx_o = '0;
      end else if (in_cell_q && !drop_q) begin
        we_o     = 1'b1;
        commit_o = last_byte;
      end
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/cellq_rd_ctl.sv
module cellq_rd_ctl #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        xfer_i,
  output logic [PW-1:0]               ptr_o,
  output logic [cellq_pkg::IDX_W-1:0] idx_o,
  output logic                        pop_o
);
  import cellq_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic [PW-1:0]    ptr_q;
  logic             last_byte;

  assign last_byte = (idx_q == IDX_W'(CELL_BYTES - 1));
  assign pop_o     = xfer_i && last_byte && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ptr_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      ptr_q <= '0;
    end else if (xfer_i) begin
      if (last_byte) begin
        idx_q <= '0;
        if (ptr_q == PW'(DEPTH - 1)) ptr_q <= '0;
        else                         ptr_q <= ptr_q + PW'(1);
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign ptr_o = ptr_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/cellq_store.sv
module cellq_store #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int DW    = 8
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [PW-1:0]               wptr_i,
  input  logic [cellq_pkg::IDX_W-1:0] widx_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [PW-1:0]               rptr_i,
  input  logic [cellq_pkg::IDX_W-1:0] ridx_i,
  output logic [DW-1:0]               rdata_o
);
  import cellq_pkg::*;

  localparam int WORDS = DEPTH * CELL_BYTES;
  localparam int AW    = $clog2(WORDS);

  logic [DW-1:0] mem_q [WORDS];
  logic [AW-1:0] waddr, raddr;

  assign waddr = AW'(wptr_i) * AW'(CELL_BYTES) + AW'(widx_i);
  assign raddr = AW'(rptr_i) * AW'(CELL_BYTES) + AW'(ridx_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr];
endmodule

// File: rtl/cellq_rx_top.sv
module cellq_rx_top #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          wr_sof_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cfg_early_i,
  input  logic          cfg_multi_i,
  input  logic          flush_req_i,
  input  logic          rd_en_ni,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_par_o,
  output logic          rd_soc_o,
  output logic          cell_avail_o,
  output logic          rd_oe_o,
  output logic          flush_busy_o,
  output logic          rx_cell_no
);
  import cellq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    count_q;
  logic             busy_q, rx_n_q;
  logic             we, commit, pop, xfer, full, has_cell, early_cut;
  logic [PW-1:0]    wptr, rptr;
  logic [IDX_W-1:0] widx, ridx;
  logic [DW-1:0]    rdata;

  assign full     = (count_q == CW'(DEPTH));
  assign has_cell = (count_q != '0);
  assign xfer     = !rd_en_ni && has_cell && !busy_q;

  cellq_wr_ctl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (busy_q),
    .valid_i  (wr_valid_i),
    .sof_i    (wr_sof_i),
    .full_i   (full),
    .we_o     (we),
    .ptr_o    (wptr),
    .idx_o    (widx),
    .commit_o (commit)
  );

  cellq_rd_ctl #(.DEPTH(DEPTH), .PW(PW)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (busy_q),
    .xfer_i (xfer),
    .ptr_o  (rptr),
    .idx_o  (ridx),
    .pop_o  (pop)
  );

  cellq_store #(.DEPTH(DEPTH), .PW(PW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .wptr_i  (wptr),
    .widx_i  (widx),
    .wdata_i (wr_data_i),
    .rptr_i  (rptr),
    .ridx_i  (ridx),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      busy_q  <= 1'b0;
      rx_n_q  <= 1'b1;
    end else begin
      if (busy_q)                count_q <= '0;
      else if (commit && !pop)   count_q <= count_q + CW'(1);
      else if (pop && !commit)   count_q <= count_q - CW'(1);
      // flush takes one cycle, a request while busy is absorbed
      if (busy_q)           busy_q <= 1'b0;
      else if (flush_req_i) busy_q <= 1'b1;
      rx_n_q <= !commit;
    end
  end

  assign early_cut    = (count_q == CW'(1)) && (ridx >= IDX_W'(EARLY_IDX));
  assign cell_avail_o = has_cell && !(cfg_early_i && early_cut);
  assign rd_data_o    = has_cell ? rdata : '0;
  assign rd_par_o     = odd_par(rd_data_o);
  assign rd_soc_o     = has_cell && (ridx == '0);
  assign rd_oe_o      = !cfg_multi_i || !rd_en_ni;
  assign flush_busy_o = busy_q;
  assign rx_cell_no   = rx_n_q;
endmodule

// File: rtl/cellq_rx_chk.sv
module cellq_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_early_i,
  input logic          cfg_multi_i,
  input logic          rd_en_ni,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_par_o,
  input logic          rd_soc_o,
  input logic          cell_avail_o,
  input logic          rd_oe_o,
  input logic          flush_busy_o,
  input logic          rx_cell_no
);
  AST_PARITY_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({rd_data_o, rd_par_o}) % 2) == 1); // R3
  AST_SOC_NEEDS_CELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_soc_o |-> cell_avail_o); // R4
  AST_SINGLE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_multi_i |-> rd_oe_o); // R7
  AST_MULTI_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_multi_i && rd_en_ni) |-> !rd_oe_o); // R8
  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |=> !flush_busy_o); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_busy_o) |-> !cell_avail_o); // R9
  AST_RX_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_cell_no |=> rx_cell_no); // R10
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cell_avail_o && !cfg_early_i) |-> (rd_data_o == '0)); // R13
endmodule

bind cellq_rx_top cellq_rx_chk #(.DW(DW)) chk_i (.*);

// File: tb/cellq_rx_top_tb_top.sv
module cellq_rx_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0, wr_sof_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       cfg_early_i = 1'b0, cfg_multi_i = 1'b0, flush_req_i = 1'b0;
  logic       rd_en_ni = 1'b1;
  logic [7:0] rd_data_o;
  logic       rd_par_o, rd_soc_o, cell_avail_o, rd_oe_o, flush_busy_o, rx_cell_no;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  cellq_rx_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic write_cell(input int seed, input int nbytes, input bit expect_q);
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk_i);
      wr_valid_i = 1'b1;
      wr_sof_i   = (k == 0);
      wr_data_i  = exp_byte(seed, k);
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    wr_sof_i   = 1'b0;
    if (nbytes == 53)
      chk(rx_cell_no == !expect_q, "R10/R11 rx pulse", rx_cell_no, !expect_q);
  endtask

  task automatic read_cell(input int seed, input bit last, input bit stall);
    for (int k = 0; k < 53; k++) begin
      @(negedge clk_i);
      chk(rd_data_o == exp_byte(seed, k), "R2 data", rd_data_o, exp_byte(seed, k));
      chk(rd_soc_o == (k == 0), "R2 soc", rd_soc_o, k == 0);
      chk(rd_par_o == ~^rd_data_o, "R3 parity", rd_par_o, ~^rd_data_o);
      chk(rd_oe_o == 1'b1, "R7 oe single", rd_oe_o, 1);
      chk(cell_avail_o == (!cfg_early_i || !last || k < 49),
          cfg_early_i ? "R6 early avail" : "R5 std avail",
          cell_avail_o, (!cfg_early_i || !last || k < 49));
      if (stall && k == 10) begin
        rd_en_ni = 1'b1;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk_i);
          chk(rd_data_o == exp_byte(seed, 10), "R2 hold", rd_data_o, exp_byte(seed, 10));
        end
      end
      rd_en_ni = 1'b0;
    end
    @(negedge clk_i);
    rd_en_ni = 1'b1;
    chk(cell_avail_o == !last, cfg_early_i ? "R6 after" : "R5 after", cell_avail_o, !last);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cell_avail_o == 0, "R1 avail", cell_avail_o, 0);
    chk(rd_soc_o == 0, "R1 soc", rd_soc_o, 0);
    chk(flush_busy_o == 0, "R1 busy", flush_busy_o, 0);
    chk(rx_cell_no == 1, "R1 rx", rx_cell_no, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rd_data_o == 0, "R13 idle data", rd_data_o, 0);

    // R5/R6 sweep over mode and queue fill
    for (int e = 0; e < 2; e++) begin
      for (int n = 1; n <= 4; n++) begin
        cfg_early_i = e[0];
        for (int c = 0; c < n; c++) write_cell(e * 40 + n * 8 + c, 53, 1'b1);
        for (int c = 0; c < n; c++) read_cell(e * 40 + n * 8 + c, c == n - 1, c == 0);
        chk(rd_data_o == 0, "R13 idle after drain", rd_data_o, 0);
      end
    end
    cfg_early_i = 1'b0;

    // R4 partial cell not offered, R12 restart
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      wr_valid_i = 1'b1; wr_sof_i = (k == 0); wr_data_i = exp_byte(99, k);
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0; wr_sof_i = 1'b0; rd_en_ni = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk_i);
      chk(cell_avail_o == 0, "R4 partial avail", cell_avail_o, 0);
      chk(rd_soc_o == 0, "R4 partial soc", rd_soc_o, 0);
    end
    rd_en_ni = 1'b1;
    write_cell(123, 53, 1'b1);
    read_cell(123, 1'b1, 1'b0);  // R12

    // R11 overflow: fifth cell dropped whole
    for (int c = 0; c < 5; c++) write_cell(200 + c, 53, c < 4);
    for (int c = 0; c < 4; c++) read_cell(200 + c, c == 3, 1'b0);
    chk(cell_avail_o == 0, "R11 nothing extra", cell_avail_o, 0);

    // R9 flush
    write_cell(60, 53, 1'b1);
    write_cell(61, 53, 1'b1);
    @(negedge clk_i);
    flush_req_i = 1'b1;
    @(negedge clk_i);
    flush_req_i = 1'b0;
    chk(flush_busy_o == 1, "R9 busy set", flush_busy_o, 1);
    @(negedge clk_i);
    chk(flush_busy_o == 0, "R9 busy clear", flush_busy_o, 0);
    chk(cell_avail_o == 0, "R9 emptied", cell_avail_o, 0);
    write_cell(77, 53, 1'b1);
    read_cell(77, 1'b1, 1'b0);

    // R8 multi-PHY enable
    cfg_multi_i = 1'b1;
    for (int v = 0; v < 2; v++) begin
      @(negedge clk_i);
      rd_en_ni = v[0];
      #1;
      chk(rd_oe_o == !v[0], "R8 multi oe", rd_oe_o, !v[0]);
    end
    rd_en_ni = 1'b1;
    #1;
    chk(rd_oe_o == 0, "R8 multi oe idle", rd_oe_o, 0);
    cfg_multi_i = 1'b0;
    #1;
    chk(rd_oe_o == 1, "R7 single oe", rd_oe_o, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule